// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address, split into a segment number and an offset inside that segment, into a physical address. It uses a small segment table that belongs to the running process. Each table slot holds a base address, a length limit, a valid flag and three access-right flags (read, write, execute). On a context switch the kernel reloads every slot and the active-segment count through a configuration write port.

A user-mode request goes through four checks, in priority order, before the base is added:
- the segment number must be below the active-segment count;
- the slot must be marked valid;
- the slot must grant the requested access type;
- the offset must be below the limit.

If any check fails, the block returns a fault code that names the first failing check, and no address is issued. Kernel-mode requests are not checked and not translated.

The result is registered. A one-cycle request strobe produces a one-cycle response strobe on the next clock, together with the physical address and the fault code.

Top module: `segxl_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_paddr are 0. Every table slot is invalid and the active-segment count is 0, so a user request issued after reset faults with code 1.
- R2: A request sampled with req_valid high gives rsp_valid high on the next clock edge. A clock edge with req_valid low gives rsp_valid, rsp_fault and rsp_paddr all 0.
- R3: A request with req_user low (kernel mode) skips every check. It returns fault 0 and rsp_paddr equal to req_laddr.
- R4: The segment number is req_laddr[7:6] and the offset is req_laddr[5:0]. A user request whose segment number is greater than or equal to the active-segment count faults with code 1.
- R5: A user request that targets a slot whose valid flag is 0 faults with code 2.
- R6: Each slot's permission field has bit 0 for read, bit 1 for write and bit 2 for execute. The req_access codes are 0 read, 1 write, 2 execute and 3 reserved. A code 3 access, or an access whose permission bit is 0, faults with code 3.
- R7: A user request whose offset is greater than or equal to the slot's limit faults with code 4. A limit of 0 faults for every offset.
- R8: A user request that passes all checks returns fault 0 and rsp_paddr = (base + offset) mod 256.
- R9: When several checks fail, the reported code is the lowest-numbered one among 1, 2, 3 and 4. No other code ever appears.
- R10: A response that carries a non-zero fault code has rsp_paddr equal to 0.
- R11: A slot write (cfg_ent_we) or a count write (cfg_cnt_we) applies to requests in later cycles. A request issued in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ent_we | input | 1 | Write one table slot |
| cfg_ent_idx | input | 2 | Slot to write |
| cfg_ent_base | input | 8 | Physical base address for the slot |
| cfg_ent_limit | input | 6 | Segment length |
| cfg_ent_valid | input | 1 | Slot valid flag |
| cfg_ent_perm | input | 3 | Access rights: bit 0 read, bit 1 write, bit 2 execute |
| cfg_cnt_we | input | 1 | Load the active-segment count |
| cfg_cnt | input | 3 | New active-segment count |
| req_valid | input | 1 | Request strobe |
| req_user | input | 1 | 1 for user mode, 0 for kernel mode |
| req_access | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_laddr | input | 8 | Logical address: segment number and offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 8 | Physical address, 0 on a fault |
| rsp_fault | output | 3 | Fault code: 0 none, 1 segment out of range, 2 invalid slot, 3 access denied, 4 offset over limit |

## Verification
On every cycle the assertions check:
- the one-cycle request-to-response timing and the all-zero idle response;
- kernel-mode pass-through;
- the segment-count fault;
- zero addresses on faults and the legal range of fault codes;
- loading of the count register.

Only the bench's scenarios can show the invalid-slot, access-rights and limit faults, their relative priority, the wrapped base-plus-offset sum and the old-contents rule for a request that coincides with a write. Those scenarios compare every response against a bench-side model of the table.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_SEG     = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_PERM    = 3'd3,
        FLT_LIMIT   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    localparam int PERM_W = 3;

endpackage

// File: rtl/segxl_table.sv
module segxl_table
    import segxl_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int BASE_W = 8,
    parameter int LIM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_we,
    input  logic [SEG_W-1:0]  ent_idx,
    input  logic [BASE_W-1:0] ent_base,
    input  logic [LIM_W-1:0]  ent_limit,
    input  logic              ent_valid,
    input  logic [PERM_W-1:0] ent_perm,
    input  logic              cnt_we,
    input  logic [SEG_W:0]    cnt_val,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_valid,
    output logic [PERM_W-1:0] rd_perm,
    output logic [SEG_W:0]    seg_count
);
    localparam int NSEG  = 1 << SEG_W;
    localparam int CNT_W = SEG_W + 1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
        logic              valid;
        logic [PERM_W-1:0] perm;
    } slot_t;

    typedef struct packed {
        slot_t [NSEG-1:0] slot;
        logic [CNT_W-1:0] cnt;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSEG; i++) begin
            if (ent_we && (ent_idx == SEG_W'(i))) begin
                st_d.slot[i].base  = ent_base;
                st_d.slot[i].limit = ent_limit;
                st_d.slot[i].valid = ent_valid;
                st_d.slot[i].perm  = ent_perm;
            end
        end
        if (cnt_we) st_d.cnt = cnt_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_base   = st_q.slot[rd_idx].base;
    assign rd_limit  = st_q.slot[rd_idx].limit;
    assign rd_valid  = st_q.slot[rd_idx].valid;
    assign rd_perm   = st_q.slot[rd_idx].perm;
    assign seg_count = st_q.cnt;

    // R11
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (seg_count == $past(cnt_val)));

endmodule

// File: rtl/segxl_check.sv
module segxl_check
    import segxl_pkg::*;
#(
    parameter int SEG_W  = 2,
    parameter int OFF_W  = 6,
    parameter int BASE_W = 8,
    parameter int LIM_W  = 6,
    parameter int PA_W   = 8
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        access,
    input  logic [SEG_W:0]    seg_count,
    input  logic [BASE_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    input  logic              valid,
    input  logic [PERM_W-1:0] perm,
    output logic [2:0]        fault,
    output logic [PA_W-1:0]   paddr
);
    localparam int CMP_W = (OFF_W > LIM_W) ? OFF_W : LIM_W;

    logic granted;
    logic in_range;
    logic under_limit;

    always_comb begin
        case (access_e'(access))
            ACC_READ:  granted = perm[0];
            ACC_WRITE: granted = perm[1];
            ACC_EXEC:  granted = perm[2];
            default:   granted = 1'b0;
        endcase
    end

    assign in_range    = {1'b0, seg} < seg_count;
    assign under_limit = CMP_W'(off) < CMP_W'(limit);

    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        if (!in_range)         fault = FLT_SEG;
        else if (!valid)       fault = FLT_INVALID;
        else if (!granted)     fault = FLT_PERM;
        else if (!under_limit) fault = FLT_LIMIT;
        else                   paddr = PA_W'(base) + PA_W'(off);
    end

endmodule

// File: rtl/segxl_unit.sv
module segxl_unit
    import segxl_pkg::*;
#(
    parameter int LA_W   = 8,
    parameter int SEG_W  = 2,
    parameter int BASE_W = 8,
    parameter int LIM_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ent_we,
    input  logic [SEG_W-1:0]  cfg_ent_idx,
    input  logic [BASE_W-1:0] cfg_ent_base,
    input  logic [LIM_W-1:0]  cfg_ent_limit,
    input  logic              cfg_ent_valid,
    input  logic [2:0]        cfg_ent_perm,
    input  logic              cfg_cnt_we,
    input  logic [SEG_W:0]    cfg_cnt,
    input  logic              req_valid,
    input  logic              req_user,
    input  logic [1:0]        req_access,
    input  logic [LA_W-1:0]   req_laddr,
    output logic              rsp_valid,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic [2:0]        rsp_fault
);
    localparam int OFF_W = LA_W - SEG_W;
    localparam int PA_W  = BASE_W;

    typedef struct packed {
        logic            valid;
        logic [2:0]      fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [SEG_W-1:0]  seg;
    logic [OFF_W-1:0]  off;
    logic [BASE_W-1:0] t_base;
    logic [LIM_W-1:0]  t_limit;
    logic              t_valid;
    logic [PERM_W-1:0] t_perm;
    logic [SEG_W:0]    seg_count;
    logic [2:0]        chk_fault;
    logic [PA_W-1:0]   chk_paddr;

    assign seg = req_laddr[LA_W-1 -: SEG_W];
    assign off = req_laddr[OFF_W-1:0];

    segxl_table #(.SEG_W(SEG_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_we    (cfg_ent_we),
        .ent_idx   (cfg_ent_idx),
        .ent_base  (cfg_ent_base),
        .ent_limit (cfg_ent_limit),
        .ent_valid (cfg_ent_valid),
        .ent_perm  (cfg_ent_perm),
        .cnt_we    (cfg_cnt_we),
        .cnt_val   (cfg_cnt),
        .rd_idx    (seg),
        .rd_base   (t_base),
        .rd_limit  (t_limit),
        .rd_valid  (t_valid),
        .rd_perm   (t_perm),
        .seg_count (seg_count)
    );

    segxl_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W),
                  .LIM_W(LIM_W), .PA_W(PA_W)) u_check (
        .seg       (seg),
        .off       (off),
        .access    (req_access),
        .seg_count (seg_count),
        .base      (t_base),
        .limit     (t_limit),
        .valid     (t_valid),
        .perm      (t_perm),
        .fault     (chk_fault),
        .paddr     (chk_paddr)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (!req_user) begin
                rsp_d.fault = FLT_NONE;
                rsp_d.paddr = PA_W'(req_laddr);
            end else begin
                rsp_d.fault = chk_fault;
                rsp_d.paddr = chk_paddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_fault = rsp_q.fault;

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_paddr == '0));

    // R3
    kernel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user) |=>
            (rsp_fault == 3'd0 && rsp_paddr == PA_W'($past(req_laddr))));

    // R4
    seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && ({1'b0, seg} >= seg_count)) |=> (rsp_fault == 3'd1));

    // R10
    fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));

    // R9
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault <= 3'd4);

endmodule

// File: tb/tb_segxl_unit.sv
`timescale 1ns/1ps
module tb_segxl_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_ent_we;
    logic [1:0] cfg_ent_idx;
    logic [7:0] cfg_ent_base;
    logic [5:0] cfg_ent_limit;
    logic       cfg_ent_valid;
    logic [2:0] cfg_ent_perm;
    logic       cfg_cnt_we;
    logic [2:0] cfg_cnt;
    logic       req_valid;
    logic       req_user;
    logic [1:0] req_access;
    logic [7:0] req_laddr;
    logic       rsp_valid;
    logic [7:0] rsp_paddr;
    logic [2:0] rsp_fault;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_base  [4];
    logic [5:0] m_limit [4];
    logic       m_valid [4];
    logic [2:0] m_perm  [4];
    logic [2:0] m_cnt;

    always #5 clk = ~clk;

    segxl_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_ent_we(cfg_ent_we), .cfg_ent_idx(cfg_ent_idx),
        .cfg_ent_base(cfg_ent_base), .cfg_ent_limit(cfg_ent_limit),
        .cfg_ent_valid(cfg_ent_valid), .cfg_ent_perm(cfg_ent_perm),
        .cfg_cnt_we(cfg_cnt_we), .cfg_cnt(cfg_cnt),
        .req_valid(req_valid), .req_user(req_user),
        .req_access(req_access), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: returns {fault, paddr}
    function automatic logic [10:0] model(input logic user, input logic [7:0] la,
                                          input logic [1:0] acc);
        logic [1:0] s;
        logic [5:0] o;
        logic       ok;
        s = la[7:6];
        o = la[5:0];
        if (!user) return {3'd0, la};
        if ({1'b0, s} >= m_cnt) return {3'd1, 8'd0};
        if (!m_valid[s]) return {3'd2, 8'd0};
        ok = (acc == 2'd3) ? 1'b0 : m_perm[s][acc];
        if (!ok) return {3'd3, 8'd0};
        if (o >= m_limit[s]) return {3'd4, 8'd0};
        return {3'd0, m_base[s] + {2'b00, o}};
    endfunction

    task automatic idle_inputs();
        cfg_ent_we = 0; cfg_cnt_we = 0; req_valid = 0;
    endtask

    task automatic drive_write(input logic [1:0] idx, input logic [7:0] b,
                               input logic [5:0] l, input logic v, input logic [2:0] p);
        cfg_ent_we = 1; cfg_ent_idx = idx; cfg_ent_base = b;
        cfg_ent_limit = l; cfg_ent_valid = v; cfg_ent_perm = p;
    endtask

    task automatic commit_write();
        m_base[cfg_ent_idx]  = cfg_ent_base;
        m_limit[cfg_ent_idx] = cfg_ent_limit;
        m_valid[cfg_ent_idx] = cfg_ent_valid;
        m_perm[cfg_ent_idx]  = cfg_ent_perm;
    endtask

    task automatic do_write(input logic [1:0] idx, input logic [7:0] b,
                            input logic [5:0] l, input logic v, input logic [2:0] p);
        @(negedge clk);
        chk("R2 idle strobe", int'(rsp_valid), 0);
        drive_write(idx, b, l, v, p);
        commit_write();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_count(input logic [2:0] c);
        @(negedge clk);
        cfg_cnt_we = 1; cfg_cnt = c; m_cnt = c;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_req(input string tag, input logic user,
                          input logic [7:0] la, input logic [1:0] acc);
        logic [10:0] e;
        @(negedge clk);
        req_valid = 1; req_user = user; req_laddr = la; req_access = acc;
        e = model(user, la, acc);
        @(negedge clk);
        idle_inputs();
        chk({tag, " R2 valid"}, int'(rsp_valid), 1);
        chk({tag, " fault"}, int'(rsp_fault), int'(e[10:8]));
        chk({tag, " paddr"}, int'(rsp_paddr), int'(e[7:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] e;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) begin
            m_base[i] = 0; m_limit[i] = 0; m_valid[i] = 0; m_perm[i] = 0;
        end
        m_cnt = 0;
        rst_n = 0;
        idle_inputs();
        req_user = 0; req_access = 0; req_laddr = 0;
        cfg_ent_idx = 0; cfg_ent_base = 0; cfg_ent_limit = 0;
        cfg_ent_valid = 0; cfg_ent_perm = 0; cfg_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 rsp_fault", int'(rsp_fault), 0);
        chk("R1 rsp_paddr", int'(rsp_paddr), 0);
        do_req("R1 empty table", 1, 8'h05, 2'd0);
        chk("R1 fault code", int'(rsp_fault), 1);

        // R3 kernel pass-through
        do_req("R3 kernel", 0, 8'hC7, 2'd3);

        // Load a process image
        do_write(2'd0, 8'h10, 6'h20, 1, 3'b101);
        do_write(2'd1, 8'h50, 6'h20, 1, 3'b011);
        do_write(2'd2, 8'h70, 6'h18, 1, 3'b011);
        do_write(2'd3, 8'hF0, 6'h3F, 1, 3'b111);
        do_count(3'd4);
        // R8 translation and wrap
        do_req("R8 seg2", 1, 8'h8C, 2'd0);
        chk("R8 value", int'(rsp_paddr), 8'h7C);
        do_req("R8 wrap", 1, 8'hE0, 2'd1);
        chk("R8 wrap value", int'(rsp_paddr), 8'h10);
        // R7 boundary
        do_req("R7 last ok", 1, 8'h97, 2'd1);
        do_req("R7 at limit", 1, 8'h98, 2'd1);
        chk("R7 code", int'(rsp_fault), 4);
        // R6 access rights
        do_req("R6 exec denied", 1, 8'h41, 2'd2);
        chk("R6 code", int'(rsp_fault), 3);
        do_req("R6 reserved", 1, 8'hC1, 2'd3);
        chk("R6 rsvd code", int'(rsp_fault), 3);
        // R5 invalid slot, also over limit and no rights: R9 priority
        do_write(2'd1, 8'h50, 6'h00, 0, 3'b000);
        do_req("R5 invalid", 1, 8'h7F, 2'd2);
        chk("R9 priority 2", int'(rsp_fault), 2);
        // R4 count bound over an invalid slot
        do_count(3'd1);
        do_req("R4 out of range", 1, 8'h40, 2'd0);
        chk("R9 priority 1", int'(rsp_fault), 1);
        // R11 same-cycle write sees old contents
        do_count(3'd4);
        @(negedge clk);
        drive_write(2'd2, 8'h00, 6'h00, 0, 3'b000);
        cfg_cnt_we = 1; cfg_cnt = 3'd0;
        req_valid = 1; req_user = 1; req_laddr = 8'h8C; req_access = 2'd0;
        e = model(1, 8'h8C, 2'd0);
        commit_write(); m_cnt = 0;
        @(negedge clk);
        idle_inputs();
        chk("R11 old fault", int'(rsp_fault), int'(e[10:8]));
        chk("R11 old paddr", int'(rsp_paddr), int'(e[7:0]));
        do_req("R11 new count", 1, 8'h8C, 2'd0);
        chk("R11 after write", int'(rsp_fault), 1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int k;
            k = int'($urandom % 10);
            if (k < 2)
                do_write(2'($urandom), 8'($urandom), 6'($urandom),
                         1'(($urandom % 4) != 0), 3'($urandom));
            else if (k == 2)
                do_count(3'($urandom % 5));
            else
                do_req("R9 random", 1'(($urandom % 4) != 0), 8'($urandom), 2'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule